// File: doc/BRIEF.md
# Dual-Channel ADC Output Bus Formatter

This block is the digital back end of a two-input sampling converter. Conversion words for the I and Q channels arrive one per rising clock edge, in alternation, each with a tag bit that says which channel it belongs to. The block delays every word by a fixed pipeline depth and then places the words on bus A alone, or splits them so that bus A carries I and bus B carries Q. Because the channels take turns, each channel runs at half the clock rate.

A mode input picks the bus arrangement. An asynchronous output-off input drops the drive flags of both buses, which stand in for tristate pads. A standby input freezes the outputs and discards the words in flight, so the pipeline starts empty when standby is released. The block also produces a latch clock at half the input clock rate, together with its inverse, for downstream capture. Each bus carries the tag of the word it shows, so alignment can be checked at the ports.

Top module: `adc_bus_fmt`

## Requirements
- R1: While reset is held and right after it is released, both buses read 0, both tags read 0, `lclk` is 0 and `lclk_n` is 1.
- R2: On every rising edge with `standby` low, `lclk` changes state. `lclk_n` is always the complement of `lclk`.
- R3: With `bus_mode` = 1 (single bus), a word accepted at edge k appears on `a_data`, with its tag on `a_tag`, right after edge k+PIPE_DEPTH (default 5). Words follow one per cycle in arrival order.
- R4: With `bus_mode` = 0 (dual bus), an I word (tag 0) that leaves the pipeline is held. When the next word to leave is a Q word (tag 1), bus A takes the held I word with `a_tag` = 0 and bus B takes the Q word with `b_tag` = 1, both on the same edge. The Q word therefore appears PIPE_DEPTH cycles after it arrives, and the I word appears one cycle later than that, counted from its own arrival.
- R5: In dual-bus mode, a Q word that leaves the pipeline without an I word directly before it leaves both buses unchanged. When two I words leave in a row, the second one replaces the first.
- R6: While `out_off` is 1, `a_drive` and `b_drive` are 0 at once, with no clock edge needed. The bus data values are not changed. With `out_off` = 0, `a_drive` is 1.
- R7: `b_drive` is 0 in single-bus mode and is equal to the inverse of `out_off` in dual-bus mode.
- R8: While `standby` is 1, input words are not accepted, and the buses, the tags and `lclk` all hold their values.
- R9: A standby edge discards every word in flight. After release, the first word to reach a bus is the one accepted at the first edge after release, and it appears PIPE_DEPTH edges later.
- R10: Word values pass through unchanged as straight binary with bit 7 as the MSB, including 8'h00 and 8'hFF. The tag encodes I as 0 and Q as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all logic uses its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 1 | 1 = single interleaved bus, 0 = dual bus (I on A, Q on B) |
| out_off | input | 1 | High turns off both bus drive flags, asynchronously |
| standby | input | 1 | High freezes outputs and discards words |
| word_in | input | 8 | Conversion word, straight binary |
| word_is_q | input | 1 | Tag of `word_in`: 0 = I, 1 = Q |
| a_data | output | 8 | Bus A value |
| a_tag | output | 1 | Channel tag of the word on bus A |
| a_drive | output | 1 | Bus A is driven (low means high impedance) |
| b_data | output | 8 | Bus B value |
| b_tag | output | 1 | Channel tag of the word on bus B |
| b_drive | output | 1 | Bus B is driven (low means high impedance) |
| lclk | output | 1 | Latch clock, input clock divided by two |
| lclk_n | output | 1 | Inverted latch clock |

## Verification
A counting ramp with alternating tags in single-bus mode shows the latency and that the order is kept. A regular I/Q alternation in dual-bus mode shows that the pairs come out aligned and that I lands on bus A and Q on bus B. Irregular tag runs (Q then Q, I then I) tell correct pairing apart from simple delayed copying. Raising the output-off input away from any edge, holding standby while the input keeps changing, and switching modes mid-stream show the asynchronous drive path, the freeze, and that no stale word appears after release.

// File: rtl/adc_bus_fmt.sv
module adc_bus_fmt #(
  parameter int W          = 8,
  parameter int PIPE_DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_mode,
  input  logic         out_off,
  input  logic         standby,
  input  logic [W-1:0] word_in,
  input  logic         word_is_q,
  output logic [W-1:0] a_data,
  output logic         a_tag,
  output logic         a_drive,
  output logic [W-1:0] b_data,
  output logic         b_tag,
  output logic         b_drive,
  output logic         lclk,
  output logic         lclk_n
);
  localparam int LAST = PIPE_DEPTH - 1;

  logic [W:0]          pw [PIPE_DEPTH];
  logic [PIPE_DEPTH-1:0] pv;
  logic [W-1:0]        held_w;
  logic                held_ok;

  wire         emerge   = pv[LAST] && !standby;
  wire         emerge_q = pw[LAST][W];
  wire [W-1:0] emerge_w = pw[LAST][W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pv <= '0;
    else if (standby) pv <= '0;
    else              pv <= {pv[PIPE_DEPTH-2:0], 1'b1};

  always_ff @(posedge clk)
    if (!standby) begin
      pw[0] <= {word_is_q, word_in};
      for (int i = 1; i < PIPE_DEPTH; i++) pw[i] <= pw[i-1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        lclk <= 1'b0;
    else if (!standby) lclk <= !lclk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      held_w  <= '0;
      held_ok <= 1'b0;
    end else if (standby || bus_mode) begin
      held_ok <= 1'b0;
    end else if (emerge) begin
      if (!emerge_q) begin
        held_w  <= emerge_w;
        held_ok <= 1'b1;
      end else begin
        held_ok <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_data <= '0;
      a_tag  <= 1'b0;
      b_data <= '0;
      b_tag  <= 1'b0;
    end else if (emerge) begin
      if (bus_mode) begin
        a_data <= emerge_w;
        a_tag  <= emerge_q;
      end else if (emerge_q && held_ok) begin
        a_data <= held_w;
        a_tag  <= 1'b0;
        b_data <= emerge_w;
        b_tag  <= 1'b1;
      end
    end

  assign lclk_n  = !lclk;
  assign a_drive = !out_off;
  assign b_drive = !out_off && !bus_mode;

  assert_lclk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !standby |=> lclk != $past(lclk));

  assert_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode && emerge) |=> (a_data == $past(emerge_w) && a_tag == $past(emerge_q)));

  assert_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_mode && emerge && emerge_q && held_ok) |=>
      (a_data == $past(held_w) && b_data == $past(emerge_w) && !a_tag && b_tag));

  assert_unpaired_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_mode && emerge && emerge_q && !held_ok) |=> ($stable(a_data) && $stable(b_data)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> ($stable(a_data) && $stable(b_data) && $stable(lclk)));

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> $countones(pv) == 0);
endmodule

// File: tb/sim_adc_bus_fmt.sv
module sim_adc_bus_fmt;
  localparam int PIPE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_mode = 1'b1, out_off = 1'b0, standby = 1'b0, word_is_q = 1'b0;
  logic [7:0] word_in = 8'h00;
  logic [7:0] a_data, b_data;
  logic a_tag, a_drive, b_tag, b_drive, lclk, lclk_n;

  always #4 clk = !clk;

  adc_bus_fmt #(.W(8), .PIPE_DEPTH(PIPE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .out_off(out_off),
    .standby(standby), .word_in(word_in), .word_is_q(word_is_q),
    .a_data(a_data), .a_tag(a_tag), .a_drive(a_drive),
    .b_data(b_data), .b_tag(b_tag), .b_drive(b_drive),
    .lclk(lclk), .lclk_n(lclk_n));

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference: input history indexed by edge number
  int  hw [0:4095];
  bit  ht [0:4095];
  bit  hacc [0:4095];
  int  e = 0, last_stby = -1;
  logic [7:0] m_a = 0, m_b = 0, held = 0;
  bit m_at = 0, m_bt = 0, m_lclk = 0, held_ok = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      e = 0; last_stby = -1; m_a = 0; m_b = 0; m_at = 0; m_bt = 0;
      m_lclk = 0; held_ok = 0; held = 0;
    end else begin
      hw[e] = int'(word_in); ht[e] = word_is_q; hacc[e] = !standby;
      if (standby) begin
        last_stby = e; held_ok = 0;
      end else begin
        int t;
        m_lclk = !m_lclk;
        t = e - PIPE;
        if (t >= 0 && hacc[t] && last_stby < t) begin
          if (bus_mode) begin
            m_a = hw[t][7:0]; m_at = ht[t];
          end else if (!ht[t]) begin
            held = hw[t][7:0]; held_ok = 1;
          end else begin
            if (held_ok) begin
              m_a = held; m_at = 0; m_b = hw[t][7:0]; m_bt = 1;
            end
            held_ok = 0;
          end
        end
        if (bus_mode) held_ok = 0;
      end
      e++;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(cur_req, "a_data", 32'(a_data), 32'(m_a));
    chk(cur_req, "a_tag R10", 32'(a_tag), 32'(m_at));
    chk(cur_req, "b_data", 32'(b_data), 32'(m_b));
    chk(cur_req, "b_tag R10", 32'(b_tag), 32'(m_bt));
    chk("R2", "lclk", 32'(lclk), 32'(m_lclk));
    chk("R2", "lclk_n", 32'(lclk_n), 32'(!m_lclk));
    chk("R6", "a_drive", 32'(a_drive), 32'(!out_off));
    chk("R7", "b_drive", 32'(b_drive), 32'(!out_off && !bus_mode));
  endtask

  task automatic step(input logic [7:0] w, input logic q);
    @(negedge clk);
    check_all();
    word_in = w;
    word_is_q = q;
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(8'h5A, 1'b1);
    rst_n = 1'b1;
    step(8'h00, 1'b0);

    // R3: single-bus ramp with alternating tags
    cur_req = "R3";
    for (int i = 0; i < 30; i++) step(8'(i * 9 + 3), 1'(i % 2));
    // R10: extreme codes
    cur_req = "R10";
    step(8'hFF, 1'b0); step(8'h00, 1'b1); step(8'h80, 1'b0); step(8'h7F, 1'b1);
    for (int i = 0; i < 6; i++) step(8'hFF, 1'(i % 2));

    // R4: dual bus, regular alternation (mode changes mid-stream)
    cur_req = "R4";
    bus_mode = 1'b0;
    for (int i = 0; i < 30; i++) step(8'(i * 37 + 11), 1'(i % 2));

    // R5: irregular tags
    cur_req = "R5";
    step(8'h11, 1'b1); step(8'h22, 1'b1); step(8'h33, 1'b0); step(8'h44, 1'b0);
    step(8'h55, 1'b1); step(8'h66, 1'b1); step(8'h77, 1'b0); step(8'h88, 1'b1);
    for (int i = 0; i < 8; i++) step(8'hC0 + 8'(i), 1'(i % 2));

    // R6: asynchronous output-off between edges
    cur_req = "R6";
    @(negedge clk);
    check_all();
    #1 out_off = 1'b1;
    #1;
    chk("R6", "a_drive async", 32'(a_drive), 32'h0);
    chk("R6", "b_drive async", 32'(b_drive), 32'h0);
    chk("R6", "a_data kept", 32'(a_data), 32'(m_a));
    for (int i = 0; i < 4; i++) step(8'hA0 + 8'(i), 1'(i % 2));
    out_off = 1'b0;
    #1 chk("R6", "a_drive restored", 32'(a_drive), 32'h1);

    // R8: standby freeze with changing input
    cur_req = "R8";
    step(8'h12, 1'b0);
    standby = 1'b1;
    for (int i = 0; i < 8; i++) step(8'hE0 + 8'(i), 1'(i % 2));
    // R9: restart after release
    cur_req = "R9";
    standby = 1'b0;
    for (int i = 0; i < 14; i++) step(8'h30 + 8'(i), 1'(i % 2));

    // R7: single bus again, bus B undriven
    cur_req = "R7";
    bus_mode = 1'b1;
    for (int i = 0; i < 10; i++) step(8'h90 + 8'(i), 1'(i % 2));
    step(8'h00, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule